// File: doc/BRIEF.md
# I2C Master Status Word and Interrupt Request

This block gathers everything software needs to know about an I2C bus master into one 16-bit status word and one level interrupt request. Event strobes from the master engine and the bus monitor (start and stop seen on the bus, a stop driven by this master, lost arbitration, missing acknowledges after an address or a data byte, a transfer ended by an empty transmit FIFO, a byte pushed into a full receive FIFO) are captured in sticky flags. Live conditions (filtered line levels, receive FIFO not empty, room in the transmit FIFO, transmit FIFO fill code) are registered each cycle.

A read strobe marks the cycle in which software reads the word. The clear-on-read flags drop at the end of that cycle unless a new event for the same flag arrives in the same cycle. A two-state machine tracks bus ownership by anyone: `BUS_IDLE` moves to `BUS_BUSY` on a start without a stop (transition "start seen"), and `BUS_BUSY` returns to `BUS_IDLE` on a stop (transition "stop seen"). All other cases hold the state.

The interrupt is a combinational OR of enabled sources over the registered word, so it follows the word in the same cycle.

Top module: `i2cm_status`

## Requirements
- R1: After reset the status word is 0x6000 (bits 14 and 13 high, all others low) and irq is low. Bits 15 and 6 always read 0.
- R2: Bit 14 equals scl_filt and bit 13 equals sda_filt as sampled on the previous clock edge.
- R3: Bit 10 (bus busy) is the state machine: it sets after a cycle with bus_start high and bus_stop low, clears after any cycle with bus_stop high, and is not changed by rd_strobe. When bus_start and bus_stop are both high while idle, it stays clear.
- R4: Bit 11 sets after a cycle with own_stop high and clears after a read. It never contributes to irq.
- R5: Bit 8 (transfer done) sets after a cycle with bus_stop high only while master_en is 1. It clears on read and raises irq when ie_done is 1.
- R6: Bit 12 (transmit underflow) sets after a cycle with tx_underflow high only while ie_tx is 1. It clears on read and does not drive irq.
- R7: Bit 9 (receive overflow) sets after a cycle with rx_push high while rx_level equals RX_DEPTH. It clears on read.
- R8: Bits 4 (address NACK), 7 (data NACK) and 5 (arbitration lost) are sticky and clear on read. Bits 4 and 7 raise irq through ie_nack, and bit 5 through ie_arb.
- R9: Bit 3 is high when rx_level was nonzero. Bit 2 is high when dir_read was 0 and tx_level was below 2. Both are sampled on the previous edge, raise irq through ie_rx and ie_tx respectively, and are not cleared by a read.
- R10: Bits [1:0] encode the previous tx_level: 0 gives 00, 1 gives 10, and 2 or more gives 11. The code 01 never appears.
- R11: When a set event and rd_strobe fall on the same cycle for a sticky bit, the bit is 1 afterwards.
- R12: irq = (b8&ie_done) | ((b4|b7)&ie_nack) | (b5&ie_arb) | (b3&ie_rx) | (b2&ie_tx), evaluated in the same cycle as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_start | input | 1 | Start condition seen on the bus |
| bus_stop | input | 1 | Stop condition seen on the bus |
| own_stop | input | 1 | This master drove a stop |
| arb_lost | input | 1 | This master lost arbitration |
| addr_nack | input | 1 | No acknowledge after address |
| data_nack | input | 1 | No acknowledge after data byte |
| tx_underflow | input | 1 | Transfer ended on empty transmit FIFO |
| rx_push | input | 1 | Byte written into receive FIFO |
| rx_level | input | RXCW | Receive FIFO occupancy |
| tx_level | input | 2 | Transmit FIFO occupancy (0..2) |
| dir_read | input | 1 | Transfer direction, 1 = read |
| master_en | input | 1 | Master enabled |
| scl_filt | input | 1 | Filtered SCL level |
| sda_filt | input | 1 | Filtered SDA level |
| rd_strobe | input | 1 | Status word read this cycle |
| ie_done | input | 1 | Transfer-done interrupt enable |
| ie_nack | input | 1 | NACK interrupt enable |
| ie_arb | input | 1 | Arbitration-lost interrupt enable |
| ie_rx | input | 1 | Receive-request interrupt enable |
| ie_tx | input | 1 | Transmit-request interrupt enable, also gates underflow |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with RX_DEPTH = 2, so rx_level is two bits wide. Every occupancy from empty to full, with and without a push, fits in a short sweep, and the overflow boundary is reached directly. Under this configuration all 128 combinations of the seven event strobes are crossed with read, master enable and transmit enable. All 32 enable patterns are crossed with a fully set and a fully cleared word. Each step is compared against an arithmetic model of the word and of irq.

// File: rtl/i2cm_stat_pkg.sv
package i2cm_stat_pkg;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_BUSY = 1'b1
    } bus_state_e;

    localparam int STAT_W   = 16;

    // status word bit positions
    localparam int B_SCL    = 14;
    localparam int B_SDA    = 13;
    localparam int B_UFLOW  = 12;
    localparam int B_OWNSTP = 11;
    localparam int B_BUSY   = 10;
    localparam int B_RXOVF  = 9;
    localparam int B_DONE   = 8;
    localparam int B_DNACK  = 7;
    localparam int B_ALOST  = 5;
    localparam int B_ANACK  = 4;
    localparam int B_RXREQ  = 3;
    localparam int B_TXREQ  = 2;

    // sticky flag slots
    localparam int SK_UFLOW  = 0;
    localparam int SK_OWNSTP = 1;
    localparam int SK_RXOVF  = 2;
    localparam int SK_DONE   = 3;
    localparam int SK_DNACK  = 4;
    localparam int SK_ALOST  = 5;
    localparam int SK_ANACK  = 6;
    localparam int SK_N      = 7;

    localparam int TX_DEPTH  = 2;

    function automatic logic [1:0] txf_code(input logic [1:0] lvl);
        logic [1:0] c;
        unique case (lvl)
            2'd0:    c = 2'b00;
            2'd1:    c = 2'b10;
            default: c = 2'b11;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/i2cm_bus_track.sv
module i2cm_bus_track
    import i2cm_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_seen,
    input  logic stop_seen,
    output logic busy
);

    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (start_seen && !stop_seen) state_d = BUS_BUSY;
            BUS_BUSY: if (stop_seen)                state_d = BUS_IDLE;
            default:                                state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == BUS_BUSY);
    end

    assert_stop_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> !busy);
    assert_start_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_seen && !stop_seen) |=> busy);

endmodule

// File: rtl/i2cm_sticky.sv
module i2cm_sticky #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic         rd_clr,
    output logic [N-1:0] flag
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flag[i] <= 1'b0;
            else if (set_ev[i]) flag[i] <= 1'b1;
            else if (rd_clr)    flag[i] <= 1'b0;
        end

        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flag[i]);
        assert_rd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr && !set_ev[i]) |=> !flag[i]);
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[i] && !rd_clr) |=> flag[i]);
    end

endmodule

// File: rtl/i2cm_level_reg.sv
module i2cm_level_reg
    import i2cm_stat_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_in,
    input  logic            sda_in,
    input  logic [RXCW-1:0] rx_level,
    input  logic [1:0]      tx_level,
    input  logic            dir_read,
    output logic            scl_q,
    output logic            sda_q,
    output logic            rx_req,
    output logic            tx_req,
    output logic [1:0]      txf
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            rx_req <= 1'b0;
            tx_req <= 1'b0;
            txf    <= 2'b00;
        end else begin
            scl_q  <= scl_in;
            sda_q  <= sda_in;
            rx_req <= (rx_level != '0);
            tx_req <= !dir_read && (int'(tx_level) < TX_DEPTH);
            txf    <= txf_code(tx_level);
        end
    end

    assert_txf_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        txf != 2'b01);
    assert_txreq_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dir_read |=> !tx_req);
    assert_txreq_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (txf != 2'b11));

endmodule

// File: rtl/i2cm_status.sv
module i2cm_status
    import i2cm_stat_pkg::*;
#(
    parameter int RX_DEPTH = 4,
    localparam int RXCW = $clog2(RX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_start,
    input  logic            bus_stop,
    input  logic            own_stop,
    input  logic            arb_lost,
    input  logic            addr_nack,
    input  logic            data_nack,
    input  logic            tx_underflow,
    input  logic            rx_push,
    input  logic [RXCW-1:0] rx_level,
    input  logic [1:0]      tx_level,
    input  logic            dir_read,
    input  logic            master_en,
    input  logic            scl_filt,
    input  logic            sda_filt,
    input  logic            rd_strobe,
    input  logic            ie_done,
    input  logic            ie_nack,
    input  logic            ie_arb,
    input  logic            ie_rx,
    input  logic            ie_tx,
    output logic [15:0]     status,
    output logic            irq
);

    logic [SK_N-1:0] set_ev;
    logic [SK_N-1:0] flag;
    logic            busy;
    logic            scl_q, sda_q, rx_req, tx_req;
    logic [1:0]      txf;
    logic            rx_full;

    always_comb begin
        rx_full           = (int'(rx_level) == RX_DEPTH);
        set_ev            = '0;
        set_ev[SK_UFLOW]  = tx_underflow && ie_tx;
        set_ev[SK_OWNSTP] = own_stop;
        set_ev[SK_RXOVF]  = rx_push && rx_full;
        set_ev[SK_DONE]   = bus_stop && master_en;
        set_ev[SK_DNACK]  = data_nack;
        set_ev[SK_ALOST]  = arb_lost;
        set_ev[SK_ANACK]  = addr_nack;
    end

    i2cm_bus_track u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_seen (bus_start),
        .stop_seen  (bus_stop),
        .busy       (busy)
    );

    i2cm_sticky #(.N(SK_N)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (set_ev),
        .rd_clr (rd_strobe),
        .flag   (flag)
    );

    i2cm_level_reg #(.RX_DEPTH(RX_DEPTH)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_filt),
        .sda_in   (sda_filt),
        .rx_level (rx_level),
        .tx_level (tx_level),
        .dir_read (dir_read),
        .scl_q    (scl_q),
        .sda_q    (sda_q),
        .rx_req   (rx_req),
        .tx_req   (tx_req),
        .txf      (txf)
    );

    always_comb begin
        status           = '0;
        status[B_SCL]    = scl_q;
        status[B_SDA]    = sda_q;
        status[B_UFLOW]  = flag[SK_UFLOW];
        status[B_OWNSTP] = flag[SK_OWNSTP];
        status[B_BUSY]   = busy;
        status[B_RXOVF]  = flag[SK_RXOVF];
        status[B_DONE]   = flag[SK_DONE];
        status[B_DNACK]  = flag[SK_DNACK];
        status[B_ALOST]  = flag[SK_ALOST];
        status[B_ANACK]  = flag[SK_ANACK];
        status[B_RXREQ]  = rx_req;
        status[B_TXREQ]  = tx_req;
        status[1:0]      = txf;
    end

    always_comb begin
        irq = (flag[SK_DONE] && ie_done)
            || ((flag[SK_ANACK] || flag[SK_DNACK]) && ie_nack)
            || (flag[SK_ALOST] && ie_arb)
            || (rx_req && ie_rx)
            || (tx_req && ie_tx);
    end

    assert_irq_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ie_done || ie_nack || ie_arb || ie_rx || ie_tx) |-> !irq);
    assert_done_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_stop && !master_en && !status[B_DONE]) |=> !status[B_DONE]);
    assert_uflow_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_underflow && !ie_tx && !status[B_UFLOW]) |=> !status[B_UFLOW]);
    assert_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !status[15] && !status[6]);

endmodule

// File: tb/tb_i2cm_status.sv
`timescale 1ns/1ps
module tb_i2cm_status;

    localparam int RXD  = 2;
    localparam int RXCW = $clog2(RXD + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic bus_start = 0, bus_stop = 0, own_stop = 0, arb_lost = 0;
    logic addr_nack = 0, data_nack = 0, tx_underflow = 0, rx_push = 0;
    logic [RXCW-1:0] rx_level = '0;
    logic [1:0] tx_level = 2'd0;
    logic dir_read = 1, master_en = 0, scl_filt = 1, sda_filt = 1, rd = 0;
    logic ie_done = 0, ie_nack = 0, ie_arb = 0, ie_rx = 0, ie_tx = 0;
    logic [15:0] status;
    logic irq;

    i2cm_status #(.RX_DEPTH(RXD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .own_stop(own_stop), .arb_lost(arb_lost), .addr_nack(addr_nack),
        .data_nack(data_nack), .tx_underflow(tx_underflow), .rx_push(rx_push),
        .rx_level(rx_level), .tx_level(tx_level), .dir_read(dir_read),
        .master_en(master_en), .scl_filt(scl_filt), .sda_filt(sda_filt),
        .rd_strobe(rd), .ie_done(ie_done), .ie_nack(ie_nack), .ie_arb(ie_arb),
        .ie_rx(ie_rx), .ie_tx(ie_tx), .status(status), .irq(irq)
    );

    // reference model state
    logic m_busy = 0, m_uf = 0, m_own = 0, m_ovf = 0, m_done = 0;
    logic m_dn = 0, m_al = 0, m_an = 0;
    logic m_scl = 1, m_sda = 1, m_rxr = 0, m_txr = 0;
    logic [1:0] m_txf = 2'b00;

    int checks = 0;
    int fails  = 0;

    function automatic logic [15:0] exp_word();
        return {1'b0, m_scl, m_sda, m_uf, m_own, m_busy, m_ovf, m_done,
                m_dn, 1'b0, m_al, m_an, m_rxr, m_txr, m_txf};
    endfunction

    function automatic logic exp_irq();
        return (m_done & ie_done) | ((m_dn | m_an) & ie_nack) | (m_al & ie_arb)
             | (m_rxr & ie_rx) | (m_txr & ie_tx);
    endfunction

    task automatic model_step();
        m_busy = m_busy ? !bus_stop : (bus_start && !bus_stop);
        m_uf   = (tx_underflow && ie_tx) || (m_uf && !rd);
        m_own  = own_stop || (m_own && !rd);
        m_ovf  = (rx_push && (int'(rx_level) == RXD)) || (m_ovf && !rd);
        m_done = (bus_stop && master_en) || (m_done && !rd);
        m_dn   = data_nack || (m_dn && !rd);
        m_al   = arb_lost || (m_al && !rd);
        m_an   = addr_nack || (m_an && !rd);
        m_scl  = scl_filt;
        m_sda  = sda_filt;
        m_rxr  = (rx_level != 0);
        m_txr  = !dir_read && (tx_level < 2);
        m_txf  = (tx_level == 0) ? 2'b00 : (tx_level == 1) ? 2'b10 : 2'b11;
    endtask

    task automatic check_w(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s status actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_b(string tag, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic zero_ev();
        bus_start = 0; bus_stop = 0; own_stop = 0; arb_lost = 0;
        addr_nack = 0; data_nack = 0; tx_underflow = 0; rx_push = 0; rd = 0;
    endtask

    // inputs are set before calling; sample 1 ns after the edge
    task automatic step(string tag);
        model_step();
        @(posedge clk);
        #1;
        check_w(tag, status, exp_word());
        check_b(tag, irq, exp_irq());
        zero_ev();
    endtask

    task automatic clear_all();
        zero_ev(); rd = 1; step("R8");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset value
        repeat (3) @(posedge clk);
        #1;
        check_w("R1", status, 16'h6000);
        check_b("R1", irq, 1'b0);
        rst_n = 1'b1;
        step("R1");

        // R2: filtered line levels
        for (int s = 0; s < 4; s++) begin
            scl_filt = s[1]; sda_filt = s[0];
            step("R2");
        end
        scl_filt = 1; sda_filt = 1;

        // R3: bus busy machine
        bus_start = 1; step("R3");
        rd = 1;        step("R3");
        bus_start = 1; step("R3");
        bus_stop = 1;  step("R3");
        bus_start = 1; bus_stop = 1; step("R3");
        check_b("R3", status[10], 1'b0);

        // R4: own stop, no irq even with every enable set
        ie_done = 1; ie_nack = 1; ie_arb = 1; ie_rx = 1; ie_tx = 1;
        dir_read = 1; rx_level = '0; tx_level = 2'd2;
        own_stop = 1; step("R4");
        check_b("R4", irq, 1'b0);
        check_b("R4", status[11], 1'b1);
        rd = 1; step("R4");
        check_b("R4", status[11], 1'b0);

        // R5: transfer done gated by master enable
        master_en = 0; bus_stop = 1; step("R5");
        check_b("R5", status[8], 1'b0);
        master_en = 1; bus_stop = 1; step("R5");
        check_b("R5", irq, 1'b1);
        rd = 1; step("R5");

        // R6: underflow gated by transmit enable
        ie_tx = 0; tx_underflow = 1; step("R6");
        check_b("R6", status[12], 1'b0);
        ie_tx = 1; tx_underflow = 1; step("R6");
        check_b("R6", status[12], 1'b1);
        check_b("R6", irq, 1'b0);
        rd = 1; step("R6");

        // R7: receive overflow at the full boundary
        for (int lv = 0; lv <= RXD; lv++) begin
            for (int p = 0; p < 2; p++) begin
                rx_level = RXCW'(lv); rx_push = p[0]; step("R7");
                rd = 1; step("R7");
            end
        end
        rx_level = '0; step("R7");

        // R8: nack and arbitration flags with their enables
        ie_done = 0; ie_rx = 0; ie_tx = 0;
        ie_nack = 1; ie_arb = 0;
        addr_nack = 1; step("R8");
        check_b("R8", irq, 1'b1);
        rd = 1; step("R8");
        data_nack = 1; step("R8");
        check_b("R8", irq, 1'b1);
        ie_nack = 0; arb_lost = 1; step("R8");
        check_b("R8", irq, 1'b0);
        ie_arb = 1; step("R8");
        check_b("R8", irq, 1'b1);
        rd = 1; step("R8");

        // R9 and R10: level bit sweep
        for (int lv = 0; lv <= RXD; lv++) begin
            for (int tl = 0; tl < 3; tl++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int e = 0; e < 4; e++) begin
                        rx_level = RXCW'(lv); tx_level = 2'(tl); dir_read = d[0];
                        ie_rx = e[0]; ie_tx = e[1];
                        step("R9");
                    end
                end
                step("R10");
            end
        end
        tx_level = 2'd3; step("R10");
        check_w("R10", {14'd0, status[1:0]}, 16'h0003);

        // R11: set event and read in the same cycle
        ie_done = 0; ie_nack = 0; ie_arb = 0; ie_rx = 0; ie_tx = 0;
        clear_all();
        addr_nack = 1; rd = 1; step("R11");
        check_b("R11", status[4], 1'b1);
        for (int ev = 0; ev < 128; ev++) begin
            for (int c = 0; c < 8; c++) begin
                {bus_start, bus_stop, own_stop, arb_lost, addr_nack, data_nack,
                 tx_underflow} = 7'(ev);
                rx_push = ev[0]; rx_level = RXCW'(RXD);
                rd = c[0]; master_en = c[1]; ie_tx = c[2];
                step("R11");
            end
        end

        // R12: enable sweep with flags set and then cleared
        rx_level = RXCW'(1); tx_level = 2'd1; dir_read = 0; master_en = 1;
        for (int phase = 0; phase < 2; phase++) begin
            if (phase == 0) begin
                bus_stop = 1; arb_lost = 1; addr_nack = 1; data_nack = 1;
                step("R12");
            end else begin
                rx_level = '0; dir_read = 1; clear_all();
            end
            for (int e = 0; e < 32; e++) begin
                {ie_done, ie_nack, ie_arb, ie_rx, ie_tx} = 5'(e);
                step("R12");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule